// File: doc/BRIEF.md
# Indirect Register Window Slave

This block is a memory-mapped slave that puts a large bank of 32-bit registers behind only two bus locations. Software first writes a register number to a select location. It then reads or writes a data window, and that access reaches whichever internal register the select value names. The register set has three control words: an identifier, a read-only version/capability word and an arbitration identifier. Behind these sit a parameterised number of 64-bit per-input entries. Each entry is reached as two 32-bit halves.

Entries are plain storage. Nothing inside the block interprets their bits. The bus side has a single address, a write strobe with data and a read strobe. Read data is registered: it appears on the clock edge that samples the read strobe and stays there until the next read.

Top module: `idx_reg_window`

## Requirements
- R1: Byte address 0x00 is the 8-bit select register. A write stores wr_data_i[7:0] and a read returns that value zero-extended. It resets to 0.
- R2: A write to the select register changes no register behind the window.
- R3: Byte address 0x10 is the data window. A write there updates the register chosen by the select value. A read there returns that register's current contents. rd_data_o takes the result on the edge that samples rd_en_i and holds it until the next read.
- R4: Index 0 is the identifier word. Only bits 27:24 are writable, every other bit reads as 0, and it resets to 0.
- R5: Index 1 is the version word and is read-only. Bits 8:0 hold the VERSION_NUM parameter, bits 23:16 hold NUM_ENTRIES-1 (23 by default), and all other bits are 0. Writes to it are ignored.
- R6: Index 2 is the arbitration word. Only bits 27:24 are writable, every other bit reads as 0, and it resets to 0.
- R7: Entry n keeps its low half at index 0x10+2n and its high half at 0x11+2n. All 32 bits of each half are writable, each half is written on its own, and every half resets to 0.
- R8: Indices 3 to 0x0F, and those at or above 0x10+2*NUM_ENTRIES, read as 0. A write to one of them leaves every register unchanged.
- R9: A bus access to any byte address other than 0x00 or 0x10 reads as 0, and a write to such an address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the bus access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |

## Verification
The hardest case to reach is a write that must have no effect: a select write, a write to an unimplemented index, or a write to a stray address. Showing that nothing changed means checking every one of the 48 entry halves afterwards. The bench therefore first fills every half with a distinct pattern. It then applies the ineffective writes. Finally it sweeps the whole index space through the window and compares each value against its own model. The sweep also reads the word just past the last entry and the gap between the control words and the first entry.

// File: rtl/idx_win_pkg.sv
package idx_win_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned IDX_W    = 8;
  localparam int unsigned VER_W    = 9;

  localparam logic [IDX_W-1:0] OFS_SEL = 8'h00;
  localparam logic [IDX_W-1:0] OFS_WIN = 8'h10;

  localparam logic [IDX_W-1:0] IDX_ID   = 8'h00;
  localparam logic [IDX_W-1:0] IDX_VER  = 8'h01;
  localparam logic [IDX_W-1:0] IDX_ARB  = 8'h02;
  localparam logic [IDX_W-1:0] IDX_ENT0 = 8'h10;

  // writable field of identifier and arbitration words
  localparam logic [DATA_W-1:0] ID_FIELD_MASK = 32'h0F00_0000;
endpackage

// File: rtl/idx_win_decode.sv
module idx_win_decode
  import idx_win_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic              sel_wr_o,
  output logic              sel_rd_o,
  output logic              win_wr_o,
  output logic              win_rd_o
);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(OFS_SEL);
  localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'(OFS_WIN);

  logic hit_sel, hit_win;

  always_comb begin
    hit_sel  = (addr_i == A_SEL);
    hit_win  = (addr_i == A_WIN);
    sel_wr_o = wr_en_i & hit_sel;
    sel_rd_o = rd_en_i & hit_sel;
    win_wr_o = wr_en_i & hit_win;
    win_rd_o = rd_en_i & hit_win;
  end
endmodule

// File: rtl/idx_win_ctrl_regs.sv
module idx_win_ctrl_regs
  import idx_win_pkg::*;
#(
  parameter int unsigned      NUM_ENTRIES = 24,
  parameter logic [VER_W-1:0] VERSION_NUM = 9'h011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              hit_o
);
  localparam logic [7:0] MAX_ENT = 8'(NUM_ENTRIES - 1);
  localparam logic [DATA_W-1:0] VER_WORD =
    {8'h00, MAX_ENT, 7'h00, VERSION_NUM};

  logic [DATA_W-1:0] id_q, arb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q  <= '0;
      arb_q <= '0;
    end else if (wr_i) begin
      if (idx_i == IDX_ID)  id_q  <= wr_data_i & ID_FIELD_MASK;
      if (idx_i == IDX_ARB) arb_q <= wr_data_i & ID_FIELD_MASK;
    end
  end

  always_comb begin
    hit_o     = 1'b1;
    rd_data_o = '0;
    unique case (idx_i)
      IDX_ID:  rd_data_o = id_q;
      IDX_VER: rd_data_o = VER_WORD;
      IDX_ARB: rd_data_o = arb_q;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/idx_win_entry_bank.sv
module idx_win_entry_bank
  import idx_win_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic                          wr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic                          hit_o,
  output logic [2*NUM_ENTRIES*DATA_W-1:0] flat_o
);
  localparam int unsigned NUM_HALVES = 2 * NUM_ENTRIES;

  logic [IDX_W-1:0]  off;
  logic [DATA_W-1:0] half_q [NUM_HALVES];

  always_comb begin
    off   = idx_i - IDX_ENT0;
    hit_o = (idx_i >= IDX_ENT0) && (32'(off) < NUM_HALVES);
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   half_q[h] <= '0;
      else if (wr_i && hit_o && (32'(off) == h))     half_q[h] <= wr_data_i;
    end
    assign flat_o[h*DATA_W +: DATA_W] = half_q[h];
  end

  always_comb begin
    rd_data_o = '0;
    for (int h = 0; h < NUM_HALVES; h++) begin
      if (hit_o && (32'(off) == h)) rd_data_o = half_q[h];
    end
  end
endmodule

// File: rtl/idx_reg_window.sv
module idx_reg_window
  import idx_win_pkg::*;
#(
  parameter int unsigned      ADDR_W      = 8,
  parameter int unsigned      NUM_ENTRIES = 24,
  parameter logic [VER_W-1:0] VERSION_NUM = 9'h011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  output logic [31:0]       rd_data_o
);
  logic sel_wr, sel_rd, win_wr, win_rd;
  logic [IDX_W-1:0]  sel_q;
  logic [DATA_W-1:0] ctrl_rd, ent_rd, rd_next, rd_q;
  logic              ctrl_hit, ent_hit;
  logic [2*NUM_ENTRIES*DATA_W-1:0] entry_flat;

  idx_win_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .sel_wr_o (sel_wr),
    .sel_rd_o (sel_rd),
    .win_wr_o (win_wr),
    .win_rd_o (win_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (sel_wr) sel_q <= wr_data_i[IDX_W-1:0];
  end

  idx_win_ctrl_regs #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .VERSION_NUM (VERSION_NUM)
  ) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (sel_q),
    .wr_i      (win_wr),
    .wr_data_i (wr_data_i),
    .rd_data_o (ctrl_rd),
    .hit_o     (ctrl_hit)
  );

  idx_win_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (sel_q),
    .wr_i      (win_wr),
    .wr_data_i (wr_data_i),
    .rd_data_o (ent_rd),
    .hit_o     (ent_hit),
    .flat_o    (entry_flat)
  );

  always_comb begin
    rd_next = '0;
    if (sel_rd)                  rd_next = DATA_W'(sel_q);
    else if (win_rd && ctrl_hit) rd_next = ctrl_rd;
    else if (win_rd && ent_hit)  rd_next = ent_rd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_next;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/idx_win_checker.sv
module idx_win_checker #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned NUM_ENTRIES = 24
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [ADDR_W-1:0]             addr_i,
  input logic                          wr_en_i,
  input logic [31:0]                   wr_data_i,
  input logic                          rd_en_i,
  input logic [31:0]                   rd_data_o,
  input logic [7:0]                    sel_q_i,
  input logic [2*NUM_ENTRIES*32-1:0]   entries_i
);
  localparam logic [ADDR_W-1:0] A_SEL = '0;
  localparam logic [ADDR_W-1:0] A_WIN = ADDR_W'(8'h10);
  localparam int unsigned       IDX_END = 16 + 2 * NUM_ENTRIES;

  logic wr_sel, win_rd, bad_addr, unimpl;
  assign wr_sel   = wr_en_i && (addr_i == A_SEL);
  assign win_rd   = rd_en_i && (addr_i == A_WIN);
  assign bad_addr = (addr_i != A_SEL) && (addr_i != A_WIN);
  assign unimpl   = (sel_q_i > 8'h02 && sel_q_i < 8'h10) || (32'(sel_q_i) >= IDX_END);

  p_sel_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel |=> sel_q_i == $past(wr_data_i[7:0]));

  p_sel_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_sel |=> $stable(sel_q_i));

  p_sel_no_side_effect_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sel |=> $stable(entries_i));

  p_rd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  p_id_field_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_rd && sel_q_i == 8'h00) |=> (rd_data_o & 32'hF0FF_FFFF) == 32'h0);

  p_ver_max_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_rd && sel_q_i == 8'h01) |=> rd_data_o[23:16] == 8'(NUM_ENTRIES - 1));

  p_arb_field_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_rd && sel_q_i == 8'h02) |=> (rd_data_o & 32'hF0FF_FFFF) == 32'h0);

  p_unimpl_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_rd && unimpl) |=> rd_data_o == 32'h0);

  p_unimpl_write_inert_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_WIN && unimpl) |=> $stable(entries_i));

  p_stray_read_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && bad_addr) |=> rd_data_o == 32'h0);

  p_stray_write_inert_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && bad_addr) |=> $stable(entries_i) && $stable(sel_q_i));
endmodule

bind idx_reg_window idx_win_checker #(
  .ADDR_W      (ADDR_W),
  .NUM_ENTRIES (NUM_ENTRIES)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_en_i   (rd_en_i),
  .rd_data_o (rd_data_o),
  .sel_q_i   (sel_q),
  .entries_i (entry_flat)
);

// File: tb/test_idx_reg_window.sv
`timescale 1ns/1ps
module test_idx_reg_window;
  localparam int unsigned NENT = 24;
  localparam int unsigned NH   = 2 * NENT;
  localparam logic [8:0]  VER  = 9'h011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;
  bit          done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  // reference model
  logic [7:0]  m_sel = '0;
  logic [31:0] m_id = '0, m_arb = '0;
  logic [31:0] m_ent [NH];

  always #2.5 clk = ~clk;

  idx_reg_window #(.NUM_ENTRIES(NENT), .VERSION_NUM(VER)) i_idx_reg_window (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_en_i   (rd_en),
    .rd_data_o (rd_data)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // monitor
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (rd_data !== e) begin
        n_fails++;
        $display("FAIL %s: got %08h expected %08h", t, rd_data, e);
      end
    end
  end

  function automatic logic [31:0] model_rd(input logic [7:0] idx);
    if (idx == 8'h00) return m_id;
    if (idx == 8'h01) return {8'h00, 8'(NENT - 1), 7'h00, VER};
    if (idx == 8'h02) return m_arb;
    if (idx >= 8'h10 && int'(idx) < 16 + NH) return m_ent[idx - 8'h10];
    return 32'h0;
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 8'h00) m_sel = d[7:0];
    else if (a == 8'h10) begin
      if (m_sel == 8'h00) m_id  = d & 32'h0F00_0000;
      if (m_sel == 8'h02) m_arb = d & 32'h0F00_0000;
      if (m_sel >= 8'h10 && int'(m_sel) < 16 + NH) m_ent[m_sel - 8'h10] = d;
    end
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic win_wr(input logic [7:0] idx, input logic [31:0] d);
    bus_wr(8'h00, {24'h0, idx});
    bus_wr(8'h10, d);
  endtask

  task automatic win_rd(input logic [7:0] idx, input string t);
    bus_wr(8'h00, {24'h0, idx});
    bus_rd(8'h10, model_rd(idx), t);
  endtask

  task automatic sweep(input string t);
    for (int i = 0; i < 16 + NH + 2; i++) win_rd(8'(i), t);
  endtask

  initial begin
    for (int i = 0; i < NH; i++) m_ent[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    bus_rd(8'h00, 32'h0, "R1 select reset");
    sweep("R7 reset sweep");
    win_rd(8'h01, "R5 version word");

    // select readback, 8-bit width
    bus_wr(8'h00, 32'h0000_01A5);
    bus_rd(8'h00, 32'h0000_00A5, "R1 select truncation");
    bus_wr(8'h00, 32'h0000_0033);
    bus_rd(8'h00, 32'h0000_0033, "R1 select readback");

    // identifier / arbitration / version
    win_wr(8'h00, 32'hFFFF_FFFF);
    win_rd(8'h00, "R4 id mask");
    win_wr(8'h00, 32'h0500_0000);
    win_rd(8'h00, "R4 id value");
    win_wr(8'h02, 32'hFFFF_FFFF);
    win_rd(8'h02, "R6 arb mask");
    win_wr(8'h02, 32'h0A12_3456);
    win_rd(8'h02, "R6 arb value");
    win_wr(8'h01, 32'hFFFF_FFFF);
    win_rd(8'h01, "R5 version write ignored");

    // fill every half with a distinct pattern
    for (int i = 0; i < NH; i++)
      win_wr(8'(16 + i), {8'(i), 8'hC3, ~8'(i), 8'(i * 7 + 1)});
    sweep("R7 pattern sweep");
    // lone half write: neighbour untouched
    win_wr(8'h11, 32'hDEAD_BEEF);
    win_rd(8'h10, "R7 low half untouched");
    win_rd(8'h11, "R7 high half written");
    win_wr(8'(16 + NH - 1), 32'h1234_5678);
    win_rd(8'(16 + NH - 1), "R7 last half");

    // select writes only latch an index
    bus_wr(8'h00, 32'h0000_0014);
    bus_wr(8'h00, 32'hFFFF_FF14);
    bus_rd(8'h10, model_rd(8'h14), "R2 select write no side effect");
    bus_rd(8'h10, model_rd(8'h14), "R3 window repeat read");

    // unimplemented indices
    win_wr(8'h05, 32'hFFFF_FFFF);
    win_wr(8'h0F, 32'hFFFF_FFFF);
    win_wr(8'(16 + NH), 32'hFFFF_FFFF);
    win_wr(8'hFF, 32'hFFFF_FFFF);
    win_rd(8'h05, "R8 gap index reads zero");
    win_rd(8'(16 + NH), "R8 past-end reads zero");
    win_rd(8'hFF, "R8 top index reads zero");

    // stray bus addresses
    bus_wr(8'h00, 32'h0000_0018);
    bus_wr(8'h04, 32'h0000_0002);
    bus_wr(8'h08, 32'hFFFF_FFFF);
    bus_wr(8'h11, 32'hFFFF_FFFF);
    bus_rd(8'h00, 32'h0000_0018, "R9 stray write keeps select");
    bus_rd(8'h08, 32'h0, "R9 stray read zero");
    bus_rd(8'h14, 32'h0, "R9 stray read zero 0x14");
    bus_rd(8'h10, model_rd(8'h18), "R9 stray write keeps entry");

    sweep("R8 final sweep");

    // read data holds while no read is issued
    win_rd(8'h02, "R3 latency");
    repeat (3) @(negedge clk);
    n_checks++;
    if (rd_data !== m_arb) begin
      n_fails++;
      $display("FAIL R3 hold: got %08h expected %08h", rd_data, m_arb);
    end

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule